// File: doc/BRIEF.md
# Glitchless Clock Output Enable

This block fans one incoming clock out to a configurable number of output lanes and switches all of them on or off together from a single asynchronous, active-low enable. Gating is arranged so that the enable only ever changes while the clock is low. As a result, a lane either emits a complete high phase or stays low for the whole cycle. No shortened pulse or spike can appear when the enable toggles.

The enable pin is brought into the clock domain by a short chain of falling-edge flops. The last flop of the chain is the gate-enable shared by every lane. Each lane has a primary output and a companion output. In differential mode the companion is the complement of the primary while the lane runs. In single-ended mode the companion is an in-phase copy. A disabled lane holds both of its outputs low in either mode. Reset clears the chain, so the outputs stay low until the enable has travelled through the synchronizer.

Top module: `clk_fanout_gate`

## Requirements
- R1: While `rst_n` is low every output is low. After reset is released, the outputs stay low until the enable has passed through the whole synchronizer chain.
- R2: While enabled (`oe_n` = 0 seen by the gate), every `clk_a` bit equals `clk_in`.
- R3: While disabled (`oe_n` = 1 seen by the gate), every `clk_a` and every `clk_b` bit is low, in both modes.
- R4: The `oe_n` level present at a falling edge of `clk_in` reaches the gate at the STAGES-th falling edge from that one (the second by default). Outputs follow from that edge on. With the default, an `oe_n` change made during a high phase first shows in the high phase two cycles later.
- R5: Each high pulse on a `clk_a` bit lasts exactly one full high phase of `clk_in`, and every `clk_a` bit is low throughout each low phase of `clk_in`.
- R6: With MODE = LANE_DIFF (encoding 1), each `clk_b` bit is the inverse of its `clk_a` bit while enabled: high in the low phase and low in the high phase.
- R7: With MODE = LANE_SINGLE (encoding 0), each `clk_b` bit equals its `clk_a` bit at all times.
- R8: All lanes carry the same value at every moment, since one enable drives them all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be distributed |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Asynchronous active-low output enable for all lanes |
| clk_a | output | LANES | Primary gated clock of each lane |
| clk_b | output | LANES | Companion of each lane: complement (differential) or copy (single-ended) |

## Verification
The bench builds two instances from the same clock and enable. One is differential with four lanes (LANES = 4, MODE = LANE_DIFF). The other is single-ended with three lanes (LANES = 3, MODE = LANE_SINGLE). Together they bring both companion behaviours and a lane count that is not a power of two within reach. `oe_n` is changed in the high phase and in the low phase of the clock. This exercises both distances to the capturing falling edge, so the two-edge latency is checked from each side. Enable toggles with random hold times, including changes on consecutive cycles, are checked against pulse widths. A reset applied in the middle of a run shows that the outputs drop and then stay low through the synchronizer refill.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;

    // Companion output behaviour of a lane
    typedef enum logic {
        LANE_SINGLE = 1'b0,   // companion is an in-phase copy
        LANE_DIFF   = 1'b1    // companion is the complement while enabled
    } lane_mode_e;

endpackage

// File: rtl/oe_resync.sv
module oe_resync #(
    parameter int STAGES = 2
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic oe_n,
    output logic gate_en
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              edge_seen;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.chain     = {st_q.chain[STAGES-2:0], ~oe_n};
        st_d.edge_seen = 1'b1;
    end

    // Falling-edge capture: the chain, and so the gate, only moves while clk_in is low
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_en = st_q.chain[STAGES-1];

    // R4
    first_stage_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
        st_q.edge_seen |-> (st_q.chain[0] == !$past(oe_n)));

    // R1
    always @(posedge clk_in) begin
        if (!rst_n) begin
            reset_gate_chk: assert (gate_en == 1'b0);
        end
    end

endmodule

// File: rtl/gated_lane.sv
module gated_lane
    import clk_fanout_pkg::*;
#(
    parameter lane_mode_e MODE = LANE_DIFF
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic gate_en,
    output logic out_a,
    output logic out_b
);

    // gate_en only changes at falling edges, so this AND never cuts a high phase
    assign out_a = clk_in & gate_en;

    generate
        if (MODE == LANE_DIFF) begin : g_diff
            assign out_b = ~clk_in & gate_en;

            // R6
            diff_low_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
                gate_en |-> (out_b && !out_a));
        end else begin : g_single
            assign out_b = out_a;
        end
    endgenerate

    // R2
    high_phase_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
        out_a == gate_en);

    // R3
    disabled_low_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
        !gate_en |-> (!out_a && !out_b));

endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
    import clk_fanout_pkg::*;
#(
    parameter int         LANES  = 4,
    parameter int         STAGES = 2,
    parameter lane_mode_e MODE   = LANE_DIFF
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             oe_n,
    output logic [LANES-1:0] clk_a,
    output logic [LANES-1:0] clk_b
);

    logic gate_en;

    oe_resync #(
        .STAGES(STAGES)
    ) resync_i (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .oe_n   (oe_n),
        .gate_en(gate_en)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            gated_lane #(
                .MODE(MODE)
            ) lane_i (
                .clk_in (clk_in),
                .rst_n  (rst_n),
                .gate_en(gate_en),
                .out_a  (clk_a[i]),
                .out_b  (clk_b[i])
            );
        end
    endgenerate

    // R8
    lanes_match_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
        (clk_a == {LANES{clk_a[0]}}) && (clk_b == {LANES{clk_b[0]}}));

endmodule

// File: tb/clk_fanout_gate_tb_top.sv
module clk_fanout_gate_tb_top;
    import clk_fanout_pkg::*;

    localparam int      LN_D = 4;
    localparam int      LN_S = 3;
    localparam realtime HALF = 10.0;   // 50 MHz

    logic            clk_in = 1'b0;
    logic            rst_n  = 1'b1;
    logic            oe_n   = 1'b0;
    logic [LN_D-1:0] da, db;
    logic [LN_S-1:0] sa, sb;

    clk_fanout_gate #(.LANES(LN_D), .STAGES(2), .MODE(LANE_DIFF)) dut_i (
        .clk_in(clk_in), .rst_n(rst_n), .oe_n(oe_n), .clk_a(da), .clk_b(db));

    clk_fanout_gate #(.LANES(LN_S), .STAGES(2), .MODE(LANE_SINGLE)) dut_se_i (
        .clk_in(clk_in), .rst_n(rst_n), .oe_n(oe_n), .clk_a(sa), .clk_b(sb));

    initial forever #(HALF) clk_in = ~clk_in;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    typedef struct {
        realtime t;
        logic    v;
    } ev_t;
    ev_t  exp_q[$];
    logic exp_gate = 1'b0;

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, expv);
        end
    endtask

    // Driver: change oe_n at a given offset after a rising edge and push the
    // time at which the gate is expected to take the new level.
    task automatic drive_oe(input logic v, input realtime off);
        realtime first_neg;
        @(posedge clk_in);
        #(off);
        oe_n = v;
        first_neg = (off < HALF) ? ($realtime + (HALF - off)) : ($realtime + (3.0 * HALF - off));
        exp_q.push_back('{first_neg + 2.0 * HALF, ~v});
    endtask

    task automatic release_reset();
        @(posedge clk_in);
        #2;
        rst_n = 1'b1;
        exp_q.push_back('{$realtime + 8.0 + 2.0 * HALF, ~oe_n});
    endtask

    task automatic assert_reset();
        @(posedge clk_in);
        #12;
        rst_n = 1'b0;
        exp_q.delete();
        exp_gate = 1'b0;
    endtask

    function automatic void update_expect();
        while (exp_q.size() > 0 && exp_q[0].t <= $realtime) begin
            exp_gate = exp_q[0].v;
            void'(exp_q.pop_front());
        end
    endfunction

    // Monitor: scoreboard pop and compare in each high and low phase
    initial begin
        string tag;
        forever begin
            @(posedge clk_in);
            #5;
            update_expect();
            tag = !rst_n ? "R1" : (exp_gate ? "R2/R8" : "R3/R8");
            check(da == {LN_D{exp_gate}}, tag, 8'(da), 8'({LN_D{exp_gate}}));
            check(db == '0, exp_gate ? "R6" : "R3", 8'(db), 8'h00);
            check(sa == {LN_S{exp_gate}}, tag, 8'(sa), 8'({LN_S{exp_gate}}));
            check(sb == {LN_S{exp_gate}}, "R7", 8'(sb), 8'({LN_S{exp_gate}}));
            #10;
            update_expect();
            check(da == '0, "R5", 8'(da), 8'h00);
            check(db == {LN_D{exp_gate}}, exp_gate ? "R6" : "R3", 8'(db), 8'({LN_D{exp_gate}}));
            check(sa == '0, "R5", 8'(sa), 8'h00);
            check(sb == '0, "R7", 8'(sb), 8'h00);
        end
    end

    // R5: every emitted high pulse is a full high phase
    realtime rise_d = -1.0;
    realtime rise_s = -1.0;
    always @(posedge da[0]) rise_d = $realtime;
    always @(posedge sa[0]) rise_s = $realtime;
    always @(negedge da[0]) begin
        if (rise_d >= 0.0) check(($realtime - rise_d) == HALF, "R5 width diff",
                                 8'(int'($realtime - rise_d)), 8'(int'(HALF)));
    end
    always @(negedge sa[0]) begin
        if (rise_s >= 0.0) check(($realtime - rise_s) == HALF, "R5 width single",
                                 8'(int'($realtime - rise_s)), 8'(int'(HALF)));
    end

    // Watchdog
    initial begin
        #(200000.0 * 2.0 * HALF);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        rst_n = 1'b0;           // R1: reset with enable asserted
        oe_n  = 1'b0;
        repeat (3) @(posedge clk_in);
        release_reset();
        // R1: first high phase after release is still low
        @(posedge clk_in);
        #6;
        check(da == '0 && sa == '0, "R1 post-release", 8'(da), 8'h00);
        repeat (6) @(posedge clk_in);

        // R4: disable in high phase; old level one cycle later, new level two later
        drive_oe(1'b1, 2.0);
        @(posedge clk_in);
        #6;
        check(da == {LN_D{1'b1}}, "R4 still on", 8'(da), 8'({LN_D{1'b1}}));
        @(posedge clk_in);
        #6;
        check(da == '0, "R4 now off", 8'(da), 8'h00);
        repeat (3) @(posedge clk_in);

        // R4: enable in low phase; captured one edge later
        drive_oe(1'b0, 12.0);
        @(posedge clk_in);
        #6;
        check(da == '0, "R4 low-phase still off", 8'(da), 8'h00);
        @(posedge clk_in);
        #6;
        check(da == '0, "R4 low-phase still off 2", 8'(da), 8'h00);
        @(posedge clk_in);
        #6;
        check(da == {LN_D{1'b1}}, "R4 low-phase on", 8'(da), 8'({LN_D{1'b1}}));

        // Random toggles, including back-to-back changes
        for (int i = 0; i < 400; i++) begin
            drive_oe(1'($urandom_range(0, 1)), ($urandom_range(0, 1) != 0) ? 12.0 : 2.0);
            repeat ($urandom_range(0, 4)) @(posedge clk_in);
        end

        // R1: reset in mid-run while enabled
        drive_oe(1'b0, 2.0);
        repeat (4) @(posedge clk_in);
        assert_reset();
        @(posedge clk_in);
        #6;
        check(da == '0 && db == '0, "R1 mid-run reset", 8'(da | db), 8'h00);
        repeat (2) @(posedge clk_in);
        release_reset();
        repeat (8) @(posedge clk_in);
        #18;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule